// File: doc/BRIEF.md
# Twelve-bit instruction ALU datapath

This block is the execute stage for the data instructions of a small accumulator machine with 12-bit instruction words. Each cycle it takes one opcode, the current accumulator value and the value already read from the addressed file register. In the same cycle it returns an 8-bit result and says whether that result goes to the accumulator or to the file register. Instructions that move data without computing also pass through this block. These are moving a literal, moving the accumulator to a file register, clearing, and setting or clearing a single bit.

The status bits carry (C), digit carry (DC) and zero (Z) live in this block as registers. Each instruction updates only its own subset of them, at the next rising clock edge. Rotations read the carry that is registered at the time. Register-file storage, program sequencing, skips, calls, returns, port direction and power control belong to other blocks. Opcodes in those groups leave this block idle.

Top module: `alu12_core`

## Requirements
- R1: While `rst_n` is low, and after it is released, the C, DC and Z flags read 0.
- R2: For a byte operation, opcode bit 5 selects where the result goes: 0 raises `w_we`, 1 raises `f_we`. `f_addr` always equals opcode bits 4:0. `w_we` and `f_we` are never high together.
- R3: Add (opcode bits 11:6 = 000111) returns W+f mod 256. It sets C on a carry out of bit 7, sets DC on a carry out of bit 3, and sets Z when the result is 0.
- R4: Subtract (bits 11:6 = 000010) returns f−W mod 256. C is 1 when no borrow leaves bit 7 (f ≥ W), DC is 1 when no borrow leaves bit 3, and Z is set when the result is 0.
- R5: AND (000101), inclusive OR (000100), exclusive OR (000110) of W with f, complement (001001), increment (001010), decrement (000011) and move (001000) of f update only Z. C and DC keep their values.
- R6: Rotate left (001101) returns {f[6:0], C}, and rotate right (001100) returns {C, f[7:1]}. Both load C with the bit shifted out and leave DC and Z unchanged.
- R7: Nibble swap (001110) returns {f[3:0], f[7:4]}. Move W to f (bits 11:5 = 0000001) writes W to the file register. Neither changes a flag.
- R8: Bit set (bits 11:8 = 0101) and bit clear (0100) write f to the file register with the bit numbered by opcode bits 7:5 forced to 1 or 0. No flag changes.
- R9: The literal operations use opcode bits 7:0 as k and write W. AND (bits 11:8 = 1110), inclusive OR (1101) and exclusive OR (1111) with k update Z. Load k (1100) changes no flag.
- R10: Clear f (bits 11:5 = 0000011) and clear W (exactly 0x040) write 0 to their destination and set Z. C and DC are unchanged.
- R11: Every other opcode drives result 0, raises no write enable and leaves all flags unchanged. This covers bits 11:5 = 0000000, the 0000010 group other than 0x040, the skip-on-zero forms 001011 and 001111, the bit tests 0110/0111, and 1000 through 1011.
- R12: Flag updates appear only after the rising clock edge that ends the instruction's cycle. Before that edge the flags show their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| opcode | input | 12 | Instruction word executed this cycle |
| w_in | input | 8 | Current accumulator value |
| f_in | input | 8 | Value of the addressed file register |
| result | output | 8 | Computed result |
| w_we | output | 1 | Write the result to the accumulator |
| f_we | output | 1 | Write the result to the file register |
| f_addr | output | 5 | File register address taken from the opcode |
| c_flag | output | 1 | Registered carry / not-borrow |
| dc_flag | output | 1 | Registered digit carry / not-borrow from bit 3 |
| z_flag | output | 1 | Registered zero flag |

## Verification
The bench builds the block with its default parameters: a 12-bit opcode, an 8-bit data path, a 5-bit file address and a 3-bit bit index. This is the only size at which the fixed instruction encoding can be decoded. At this size, single vectors reach the real carry corners. These include 0x0F+0x01, which carries out of bit 3 but not bit 7, and 0x80+0x80, which carries out of bit 7 and gives zero. They also include subtractions that borrow at bit 3 but not at bit 7, and increments and decrements that wrap. The vectors run in a fixed order, so flags left by one vector feed the rotates that follow and show whether later operations keep or change them.

// File: rtl/alu12_pkg.sv
package alu12_pkg;

    typedef enum logic [4:0] {
        OP_NOP,
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_IOR,
        OP_XOR,
        OP_COM,
        OP_INC,
        OP_DEC,
        OP_MOVF,
        OP_MOVWF,
        OP_RLF,
        OP_RRF,
        OP_SWAP,
        OP_CLRF,
        OP_CLRW,
        OP_BCF,
        OP_BSF,
        OP_ANDL,
        OP_IORL,
        OP_XORL,
        OP_MOVL
    } alu_op_e;

    typedef enum logic [1:0] {
        DST_NONE,
        DST_W,
        DST_F
    } dest_e;

    typedef struct packed {
        logic c;
        logic dc;
        logic z;
    } flag_t;

endpackage

// File: rtl/alu12_decode.sv
module alu12_decode
    import alu12_pkg::*;
#(
    parameter int OPC_W  = 12,
    parameter int ADDR_W = 5,
    parameter int BIT_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic [OPC_W-1:0]  opcode,
    output alu_op_e           op,
    output dest_e             dest,
    output logic [BIT_W-1:0]  bit_idx,
    output logic [DATA_W-1:0] literal,
    output logic [ADDR_W-1:0] addr
);
    localparam int DBIT = ADDR_W;

    dest_e byte_dest;

    assign byte_dest = opcode[DBIT] ? DST_F : DST_W;
    assign bit_idx   = opcode[ADDR_W+BIT_W-1:ADDR_W];
    assign literal   = opcode[DATA_W-1:0];
    assign addr      = opcode[ADDR_W-1:0];

    always_comb begin
        op   = OP_NOP;
        dest = DST_NONE;
        unique casez (opcode)
            12'b0000_001?_????: begin op = OP_MOVWF; dest = DST_F;     end
            12'b0000_011?_????: begin op = OP_CLRF;  dest = DST_F;     end
            12'b0000_0100_0000: begin op = OP_CLRW;  dest = DST_W;     end
            12'b0000_10??_????: begin op = OP_SUB;   dest = byte_dest; end
            12'b0000_11??_????: begin op = OP_DEC;   dest = byte_dest; end
            12'b0001_00??_????: begin op = OP_IOR;   dest = byte_dest; end
            12'b0001_01??_????: begin op = OP_AND;   dest = byte_dest; end
            12'b0001_10??_????: begin op = OP_XOR;   dest = byte_dest; end
            12'b0001_11??_????: begin op = OP_ADD;   dest = byte_dest; end
            12'b0010_00??_????: begin op = OP_MOVF;  dest = byte_dest; end
            12'b0010_01??_????: begin op = OP_COM;   dest = byte_dest; end
            12'b0010_10??_????: begin op = OP_INC;   dest = byte_dest; end
            12'b0011_00??_????: begin op = OP_RRF;   dest = byte_dest; end
            12'b0011_01??_????: begin op = OP_RLF;   dest = byte_dest; end
            12'b0011_10??_????: begin op = OP_SWAP;  dest = byte_dest; end
            12'b0100_????_????: begin op = OP_BCF;   dest = DST_F;     end
            12'b0101_????_????: begin op = OP_BSF;   dest = DST_F;     end
            12'b1100_????_????: begin op = OP_MOVL;  dest = DST_W;     end
            12'b1101_????_????: begin op = OP_IORL;  dest = DST_W;     end
            12'b1110_????_????: begin op = OP_ANDL;  dest = DST_W;     end
            12'b1111_????_????: begin op = OP_XORL;  dest = DST_W;     end
            default:            begin op = OP_NOP;   dest = DST_NONE;  end
        endcase
    end

endmodule

// File: rtl/alu12_exec.sv
module alu12_exec
    import alu12_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BIT_W  = 3
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] w_val,
    input  logic [DATA_W-1:0] f_val,
    input  logic [DATA_W-1:0] literal,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              c_cur,
    output logic [DATA_W-1:0] result,
    output flag_t             flag_new,
    output flag_t             flag_upd
);
    localparam int NIB_W = DATA_W / 2;

    logic [DATA_W:0]   add_full;
    logic [NIB_W:0]    add_half;
    logic [DATA_W:0]   sub_full;
    logic [NIB_W:0]    sub_half;
    logic [DATA_W-1:0] bit_mask;

    assign add_full = {1'b0, w_val} + {1'b0, f_val};
    assign add_half = {1'b0, w_val[NIB_W-1:0]} + {1'b0, f_val[NIB_W-1:0]};
    assign sub_full = {1'b0, f_val} + {1'b0, ~w_val} + {{DATA_W{1'b0}}, 1'b1};
    assign sub_half = {1'b0, f_val[NIB_W-1:0]} + {1'b0, ~w_val[NIB_W-1:0]}
                    + {{NIB_W{1'b0}}, 1'b1};
    assign bit_mask = {{(DATA_W-1){1'b0}}, 1'b1} << bit_idx;

    always_comb begin
        result       = '0;
        flag_new     = '0;
        flag_upd     = '0;
        unique case (op)
            OP_ADD: begin
                result      = add_full[DATA_W-1:0];
                flag_new.c  = add_full[DATA_W];
                flag_new.dc = add_half[NIB_W];
                flag_upd.c  = 1'b1;
                flag_upd.dc = 1'b1;
                flag_upd.z  = 1'b1;
            end
            OP_SUB: begin
                result      = sub_full[DATA_W-1:0];
                flag_new.c  = sub_full[DATA_W];
                flag_new.dc = sub_half[NIB_W];
                flag_upd.c  = 1'b1;
                flag_upd.dc = 1'b1;
                flag_upd.z  = 1'b1;
            end
            OP_AND:  begin result = w_val & f_val;  flag_upd.z = 1'b1; end
            OP_IOR:  begin result = w_val | f_val;  flag_upd.z = 1'b1; end
            OP_XOR:  begin result = w_val ^ f_val;  flag_upd.z = 1'b1; end
            OP_COM:  begin result = ~f_val;         flag_upd.z = 1'b1; end
            OP_INC:  begin result = f_val + 1'b1;   flag_upd.z = 1'b1; end
            OP_DEC:  begin result = f_val - 1'b1;   flag_upd.z = 1'b1; end
            OP_MOVF: begin result = f_val;          flag_upd.z = 1'b1; end
            OP_MOVWF: result = w_val;
            OP_RLF: begin
                result     = {f_val[DATA_W-2:0], c_cur};
                flag_new.c = f_val[DATA_W-1];
                flag_upd.c = 1'b1;
            end
            OP_RRF: begin
                result     = {c_cur, f_val[DATA_W-1:1]};
                flag_new.c = f_val[0];
                flag_upd.c = 1'b1;
            end
            OP_SWAP: result = {f_val[NIB_W-1:0], f_val[DATA_W-1:NIB_W]};
            OP_CLRF, OP_CLRW: begin
                result     = '0;
                flag_upd.z = 1'b1;
            end
            OP_BCF:  result = f_val & ~bit_mask;
            OP_BSF:  result = f_val | bit_mask;
            OP_ANDL: begin result = w_val & literal; flag_upd.z = 1'b1; end
            OP_IORL: begin result = w_val | literal; flag_upd.z = 1'b1; end
            OP_XORL: begin result = w_val ^ literal; flag_upd.z = 1'b1; end
            OP_MOVL: result = literal;
            default: result = '0;
        endcase
        flag_new.z = (result == '0);
    end

endmodule

// File: rtl/alu12_status.sv
module alu12_status
    import alu12_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  flag_t flag_new,
    input  flag_t flag_upd,
    output flag_t flag_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            if (flag_upd.c)  flag_q.c  <= flag_new.c;
            if (flag_upd.dc) flag_q.dc <= flag_new.dc;
            if (flag_upd.z)  flag_q.z  <= flag_new.z;
        end
    end

endmodule

// File: rtl/alu12_core.sv
module alu12_core
    import alu12_pkg::*;
#(
    parameter int OPC_W  = 12,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5,
    parameter int BIT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] w_in,
    input  logic [DATA_W-1:0] f_in,
    output logic [DATA_W-1:0] result,
    output logic              w_we,
    output logic              f_we,
    output logic [ADDR_W-1:0] f_addr,
    output logic              c_flag,
    output logic              dc_flag,
    output logic              z_flag
);
    alu_op_e           dec_op;
    dest_e             dec_dest;
    logic [BIT_W-1:0]  dec_bit;
    logic [DATA_W-1:0] dec_lit;
    flag_t             flag_new;
    flag_t             flag_upd;
    flag_t             flag_q;

    alu12_decode #(
        .OPC_W (OPC_W),
        .ADDR_W(ADDR_W),
        .BIT_W (BIT_W),
        .DATA_W(DATA_W)
    ) u_decode (
        .opcode (opcode),
        .op     (dec_op),
        .dest   (dec_dest),
        .bit_idx(dec_bit),
        .literal(dec_lit),
        .addr   (f_addr)
    );

    alu12_exec #(
        .DATA_W(DATA_W),
        .BIT_W (BIT_W)
    ) u_exec (
        .op      (dec_op),
        .w_val   (w_in),
        .f_val   (f_in),
        .literal (dec_lit),
        .bit_idx (dec_bit),
        .c_cur   (flag_q.c),
        .result  (result),
        .flag_new(flag_new),
        .flag_upd(flag_upd)
    );

    alu12_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .flag_new(flag_new),
        .flag_upd(flag_upd),
        .flag_q  (flag_q)
    );

    assign w_we    = (dec_dest == DST_W);
    assign f_we    = (dec_dest == DST_F);
    assign c_flag  = flag_q.c;
    assign dc_flag = flag_q.dc;
    assign z_flag  = flag_q.z;

endmodule

// File: rtl/alu12_core_chk.sv
module alu12_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] opcode,
    input logic [7:0]  f_in,
    input logic [7:0]  result,
    input logic        w_we,
    input logic        f_we,
    input logic        c_flag,
    input logic        dc_flag,
    input logic        z_flag
);
    logic is_idle;
    assign is_idle = (opcode[11:5] == 7'b0000000);

    assert_one_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(w_we && f_we));

    assert_add_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[11:6] == 6'b000111) |-> (f_we == opcode[5]) && (w_we == !opcode[5]));

    assert_rlf_cin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[11:6] == 6'b001101) |-> (result[0] == c_flag));

    assert_rlf_cout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[11:6] == 6'b001101) |=> (c_flag == $past(f_in[7])));

    assert_swap_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[11:6] == 6'b001110) |=> $stable({c_flag, dc_flag, z_flag}));

    assert_bsf_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[11:8] == 4'b0101) |-> f_we && result[opcode[7:5]]);

    assert_bcf_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[11:8] == 4'b0100) |-> f_we && !result[opcode[7:5]]);

    assert_literal_to_w_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[11:10] == 2'b11) |-> w_we && !f_we);

    assert_clrf_sets_z_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[11:5] == 7'b0000011) |=> z_flag);

    assert_idle_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle |-> !w_we && !f_we && (result == 8'h00));

    assert_idle_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle |=> $stable({c_flag, dc_flag, z_flag}));

endmodule

bind alu12_core alu12_core_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (opcode),
    .f_in   (f_in),
    .result (result),
    .w_we   (w_we),
    .f_we   (f_we),
    .c_flag (c_flag),
    .dc_flag(dc_flag),
    .z_flag (z_flag)
);

// File: tb/test_alu12_core.sv
module test_alu12_core;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NVEC       = 32;

    // {opcode, w, f, result, w_we, f_we, {c,dc,z} after the edge}
    localparam logic [40:0] VEC [NVEC] = '{
        {12'h1C3, 8'h0F, 8'h01, 8'h10, 1'b1, 1'b0, 3'b010},
        {12'h1E3, 8'h80, 8'h80, 8'h00, 1'b0, 1'b1, 3'b101},
        {12'h085, 8'h06, 8'h05, 8'hFF, 1'b1, 1'b0, 3'b000},
        {12'h085, 8'h01, 8'h10, 8'h0F, 1'b1, 1'b0, 3'b100},
        {12'h0A5, 8'h33, 8'h33, 8'h00, 1'b0, 1'b1, 3'b111},
        {12'h145, 8'hF0, 8'h0F, 8'h00, 1'b1, 1'b0, 3'b111},
        {12'h125, 8'h0F, 8'h30, 8'h3F, 1'b0, 1'b1, 3'b110},
        {12'h305, 8'h00, 8'h02, 8'h81, 1'b1, 1'b0, 3'b010},
        {12'h365, 8'h00, 8'h81, 8'h02, 1'b0, 1'b1, 3'b110},
        {12'h385, 8'h00, 8'hA5, 8'h5A, 1'b1, 1'b0, 3'b110},
        {12'h2A5, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b1, 3'b111},
        {12'h0C5, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b0, 3'b110},
        {12'h245, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0, 3'b111},
        {12'h205, 8'h00, 8'h7E, 8'h7E, 1'b1, 1'b0, 3'b110},
        {12'h1A5, 8'h55, 8'h55, 8'h00, 1'b0, 1'b1, 3'b111},
        {12'h5E5, 8'h00, 8'h00, 8'h80, 1'b0, 1'b1, 3'b111},
        {12'h405, 8'h00, 8'hFF, 8'hFE, 1'b0, 1'b1, 3'b111},
        {12'hE0F, 8'hF3, 8'h00, 8'h03, 1'b1, 1'b0, 3'b110},
        {12'hC00, 8'h77, 8'h00, 8'h00, 1'b1, 1'b0, 3'b110},
        {12'hD00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 3'b111},
        {12'hFAA, 8'h55, 8'h00, 8'hFF, 1'b1, 1'b0, 3'b110},
        {12'h065, 8'h00, 8'h9C, 8'h00, 1'b0, 1'b1, 3'b111},
        {12'h025, 8'h3C, 8'h00, 8'h3C, 1'b0, 1'b1, 3'b111},
        {12'hD01, 8'h00, 8'h00, 8'h01, 1'b1, 1'b0, 3'b110},
        {12'h040, 8'hAA, 8'h55, 8'h00, 1'b1, 1'b0, 3'b111},
        {12'h003, 8'h11, 8'h22, 8'h00, 1'b0, 1'b0, 3'b111},
        {12'h2E5, 8'h11, 8'h01, 8'h00, 1'b0, 1'b0, 3'b111},
        {12'h8FF, 8'h11, 8'h01, 8'h00, 1'b0, 1'b0, 3'b111},
        {12'h041, 8'h11, 8'h01, 8'h00, 1'b0, 1'b0, 3'b111},
        {12'h1C3, 8'h01, 8'h01, 8'h02, 1'b1, 1'b0, 3'b000},
        {12'h605, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'b000},
        {12'hA00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 3'b000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] opcode = 12'h000;
    logic [7:0]  w_in = 8'h00;
    logic [7:0]  f_in = 8'h00;
    logic [7:0]  result;
    logic        w_we;
    logic        f_we;
    logic [4:0]  f_addr;
    logic        c_flag;
    logic        dc_flag;
    logic        z_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu12_core i_alu12_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .w_in   (w_in),
        .f_in   (f_in),
        .result (result),
        .w_we   (w_we),
        .f_we   (f_we),
        .f_addr (f_addr),
        .c_flag (c_flag),
        .dc_flag(dc_flag),
        .z_flag (z_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [11:0] op);
        if (op[11:6] == 6'b000111) return "R3";
        if (op[11:6] == 6'b000010) return "R4";
        if (op[11:6] == 6'b001100 || op[11:6] == 6'b001101) return "R6";
        if (op[11:6] == 6'b001110 || op[11:5] == 7'b0000001) return "R7";
        if (op[11:9] == 3'b010) return "R8";
        if (op[11:10] == 2'b11) return "R9";
        if (op[11:5] == 7'b0000011 || op == 12'h040) return "R10";
        if (op[11:6] == 6'b000101 || op[11:6] == 6'b000100 || op[11:6] == 6'b000110 ||
            op[11:6] == 6'b001001 || op[11:6] == 6'b001010 || op[11:6] == 6'b000011 ||
            op[11:6] == 6'b001000) return "R5";
        return "R11";
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 flags in reset", {29'd0, c_flag, dc_flag, z_flag}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 flags after release", {29'd0, c_flag, dc_flag, z_flag}, 32'd0);

        foreach (VEC[i]) begin
            logic [40:0] v;
            string       rq;
            v = VEC[i];
            rq = req_of(v[40:29]);
            @(negedge clk);
            opcode = v[40:29];
            w_in   = v[28:21];
            f_in   = v[20:13];
            #1;
            check({rq, " result"}, {24'd0, result}, {24'd0, v[12:5]});
            check({rq, " R2 w_we"}, {31'd0, w_we}, {31'd0, v[4]});
            check({rq, " R2 f_we"}, {31'd0, f_we}, {31'd0, v[3]});
            check("R2 f_addr", {27'd0, f_addr}, {27'd0, v[33:29]});
            @(posedge clk);
            #1;
            check({rq, " flags"}, {29'd0, c_flag, dc_flag, z_flag}, {29'd0, v[2:0]});
        end

        // R12: flags change only at the edge. Flags are 000 here.
        @(negedge clk);
        opcode = 12'h1E3;
        w_in   = 8'h80;
        f_in   = 8'h80;
        #2;
        check("R12 flags before edge", {29'd0, c_flag, dc_flag, z_flag}, 32'd0);
        @(posedge clk);
        #1;
        check("R12 flags after edge", {29'd0, c_flag, dc_flag, z_flag}, 32'd5);

        // R1: reset mid-run clears flags
        @(negedge clk);
        opcode = 12'h000;
        rst_n  = 1'b0;
        #1;
        check("R1 async clear", {29'd0, c_flag, dc_flag, z_flag}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: rotate right with carry 0 after reset, bit 0 out sets C
        @(negedge clk);
        opcode = 12'h305;
        f_in   = 8'h01;
        #1;
        check("R6 rrf result", {24'd0, result}, 32'h00);
        @(posedge clk);
        #1;
        check("R6 rrf carry out", {29'd0, c_flag, dc_flag, z_flag}, 32'd4);

        @(negedge clk);
        opcode = 12'h000;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule